// File: doc/BRIEF.md
# Fixed-Slice Memory Window Decoder

This block decides whether a memory address falls into one of a set of hard-wired windows. Each window is an 8 MB slice of the 256 MB region whose top address nibble is 0xF. Slice number i starts at 0xF0000000 plus (i << 23) and covers 0x800000 bytes. A 32-bit enable register holds one bit per slice, so bit i claims slice i. There are no base and limit pairs. When the register holds zero, no address range is claimed at all. Setting neighbouring bits gives one larger contiguous range, and no extra logic is involved.

Software programs the enable register through a simple register port. The port has a write strobe, an offset and write data. Read data is combinational for the offset on the port. An add-in-card style setup writes a one-hot value that selects one of slices 1 to 30.

Address lookups are combinational. The block reports a hit and the 5-bit index of the matching slice. An optional output stage delays the lookup result by one clock. That stage has a plain valid flag and no back-pressure: a result comes out every cycle, and the consumer must take it when valid is high, because the block has no ready input and never stalls.

Top module: `mem_window_decoder`

## Requirements
- R1: After reset, the enable register reads as zero, no address hits, and `q_valid` is low.
- R2: A write with `reg_we` high and `reg_addr` equal to 0x060 stores `reg_wdata` in the enable register. A read at offset 0x060 returns that value unchanged.
- R3: A write to any offset other than 0x060 leaves the enable register unchanged. A read at any other offset returns zero.
- R4: `lk_hit` is high exactly when `lk_addr[31:28]` is 0xF and enable bit number `lk_addr[27:23]` is set. On a hit, `lk_idx` equals `lk_addr[27:23]`. Addresses whose top nibble is not 0xF never hit.
- R5: Slice i spans 0xF0000000 + (i << 23) through that start + 0x7FFFFF, both ends inclusive. With only bit i enabled, the addresses one below the start and one above the end miss.
- R6: With the enable register at zero, no address hits.
- R7: When `lk_hit` is low, `lk_idx` is zero.
- R8: Adjacent enabled bits decode as one unbroken range. Each address in the range reports the index of its own slice.
- R9: With the registered stage enabled (the default), `q_valid`, `q_hit` and `q_idx` show one clock later the values that `lk_valid`, `lk_hit` and `lk_idx` had. `q_hit` is never high while `q_valid` is low.
- R10: A lookup already sees a new enable value in the cycle right after the clock edge that wrote it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| lk_valid | input | 1 | Lookup address is valid (used by the registered stage) |
| lk_addr | input | 32 | Address to decode |
| lk_hit | output | 1 | Combinational hit |
| lk_idx | output | 5 | Combinational slice index, zero on a miss |
| q_valid | output | 1 | Registered result valid |
| q_hit | output | 1 | Registered hit |
| q_idx | output | 5 | Registered slice index |

## Verification
The assertions check on every cycle that the decode agrees with the register state:
- a hit always has the region nibble and a set enable bit;
- a miss carries index zero;
- an all-zero register never hits;
- writes either land or, at a wrong offset, leave the register untouched;
- the output stage follows its input one clock late.

Some properties only the directed scenarios can show, because they need concrete addresses:
- the exact inclusive slice edges one byte on either side;
- the highest card-mode slice;
- seamless coverage across adjacent enabled slices;
- the rejection of addresses outside the region while every bit is enabled.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
  // Register select produced by the offset decode
  typedef enum logic [0:0] {
    SEL_NONE   = 1'b0,
    SEL_ENABLE = 1'b1
  } mwd_sel_e;

  localparam int unsigned MWD_ADDR_W  = 32;
  localparam int unsigned MWD_SHIFT   = 23;
  localparam int unsigned MWD_REG_AW  = 12;
  localparam logic [11:0] MWD_EN_OFF  = 12'h060;
endpackage

// File: rtl/mwd_enable_reg.sv
module mwd_enable_reg
  import mwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_AW = 12,
  parameter logic [REG_AW-1:0] EN_OFF = 12'h060
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] en
);
  mwd_sel_e sel;
  logic [DATA_W-1:0] en_r;

  always_comb begin
    sel = (addr == EN_OFF) ? SEL_ENABLE : SEL_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_r <= '0;
    end else if (we && sel == SEL_ENABLE) begin
      en_r <= wdata;
    end
  end

  always_comb begin
    case (sel)
      SEL_ENABLE: rdata = en_r;
      default:    rdata = '0;
    endcase
  end

  assign en = en_r;
endmodule

// File: rtl/mwd_match.sv
module mwd_match #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SHIFT  = 23,
  parameter int unsigned IDX_W  = 5,
  localparam int unsigned NWIN  = 1 << IDX_W,
  localparam int unsigned TAG_W = ADDR_W - SHIFT - IDX_W,
  localparam logic [TAG_W-1:0] TAG = '1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [NWIN-1:0]   en,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  logic             tag_ok;
  logic [IDX_W-1:0] slice;
  logic [NWIN-1:0]  win_sel;

  assign tag_ok = (addr[ADDR_W-1 -: TAG_W] == TAG);
  assign slice  = addr[SHIFT +: IDX_W];

  // One comparator per slice; at most one can fire
  for (genvar i = 0; i < NWIN; i++) begin : g_win
    assign win_sel[i] = tag_ok && en[i] && (slice == IDX_W'(i));
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (win_sel[i]) idx = idx | IDX_W'(i);
    end
  end

  assign hit = |win_sel;
endmodule

// File: rtl/mwd_out_stage.sv
module mwd_out_stage #(
  parameter bit          REG_OUT = 1'b1,
  parameter int unsigned IDX_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_hit,
  input  logic [IDX_W-1:0] in_idx,
  output logic             out_valid,
  output logic             out_hit,
  output logic [IDX_W-1:0] out_idx
);
  if (REG_OUT) begin : g_reg
    logic             v_q;
    logic             h_q;
    logic [IDX_W-1:0] i_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        h_q <= 1'b0;
        i_q <= '0;
      end else begin
        v_q <= in_valid;
        h_q <= in_valid && in_hit;
        i_q <= in_valid ? in_idx : '0;
      end
    end
    assign out_valid = v_q;
    assign out_hit   = h_q;
    assign out_idx   = i_q;
  end else begin : g_pass
    assign out_valid = in_valid;
    assign out_hit   = in_valid && in_hit;
    assign out_idx   = in_valid ? in_idx : '0;
  end
endmodule

// File: rtl/mem_window_decoder.sv
module mem_window_decoder
  import mwd_pkg::*;
#(
  parameter int unsigned ADDR_W  = MWD_ADDR_W,
  parameter int unsigned SHIFT   = MWD_SHIFT,
  parameter int unsigned REG_AW  = MWD_REG_AW,
  parameter logic [REG_AW-1:0] EN_OFF = MWD_EN_OFF,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned IDX_W  = 5,
  localparam int unsigned NWIN   = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [NWIN-1:0]   reg_wdata,
  output logic [NWIN-1:0]   reg_rdata,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic              q_valid,
  output logic              q_hit,
  output logic [IDX_W-1:0]  q_idx
);
  logic [NWIN-1:0] en_q;

  mwd_enable_reg #(
    .DATA_W(NWIN), .REG_AW(REG_AW), .EN_OFF(EN_OFF)
  ) u_reg (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .en(en_q)
  );

  mwd_match #(
    .ADDR_W(ADDR_W), .SHIFT(SHIFT), .IDX_W(IDX_W)
  ) u_match (
    .addr(lk_addr), .en(en_q), .hit(lk_hit), .idx(lk_idx)
  );

  mwd_out_stage #(
    .REG_OUT(REG_OUT), .IDX_W(IDX_W)
  ) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(lk_valid), .in_hit(lk_hit),
    .in_idx(lk_idx), .out_valid(q_valid), .out_hit(q_hit), .out_idx(q_idx)
  );
endmodule

// File: rtl/mwd_checker.sv
module mwd_checker #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned SHIFT   = 23,
  parameter int unsigned REG_AW  = 12,
  parameter logic [REG_AW-1:0] EN_OFF = 12'h060,
  parameter bit          REG_OUT = 1'b1,
  parameter int unsigned IDX_W   = 5,
  localparam int unsigned NWIN   = 1 << IDX_W,
  localparam int unsigned TAG_W  = ADDR_W - SHIFT - IDX_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic [NWIN-1:0]   reg_wdata,
  input logic              lk_valid,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              lk_hit,
  input logic [IDX_W-1:0]  lk_idx,
  input logic              q_valid,
  input logic              q_hit,
  input logic [IDX_W-1:0]  q_idx,
  input logic [NWIN-1:0]   en_q
);
  // R4
  hit_needs_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_addr[ADDR_W-1 -: TAG_W] == '1) && en_q[lk_idx]
               && (lk_idx == lk_addr[SHIFT +: IDX_W]));

  // R7
  miss_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> lk_idx == '0);

  // R6
  zero_en_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !lk_hit);

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == EN_OFF) |=> en_q == $past(reg_wdata));

  // R3
  stray_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr != EN_OFF) |=> $stable(en_q));

  // R9
  q_hit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_hit |-> q_valid);

  if (REG_OUT) begin : g_regchk
    // R9
    q_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lk_valid) |-> q_valid && (q_hit == $past(lk_hit))
                          && (q_idx == $past(lk_idx)));
  end
endmodule

bind mem_window_decoder mwd_checker #(
  .ADDR_W(ADDR_W), .SHIFT(SHIFT), .REG_AW(REG_AW), .EN_OFF(EN_OFF),
  .REG_OUT(REG_OUT), .IDX_W(IDX_W)
) u_mwd_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
  .lk_hit(lk_hit), .lk_idx(lk_idx), .q_valid(q_valid), .q_hit(q_hit),
  .q_idx(q_idx), .en_q(en_q)
);

// File: tb/mem_window_decoder_bench.sv
module mem_window_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        lk_hit;
  logic [4:0]  lk_idx;
  logic        q_valid;
  logic        q_hit;
  logic [4:0]  q_idx;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_window_decoder u_mem_window_decoder (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_idx(lk_idx),
    .q_valid(q_valid), .q_hit(q_hit), .q_idx(q_idx)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_checks, n_fails);
    $finish;
  endtask

  task automatic reg_write(input logic [11:0] off, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = off; reg_wdata = d;
    @(posedge clk);
    #1 reg_we = 1'b0;
  endtask

  task automatic reg_read_chk(input logic [11:0] off, input logic [31:0] exp,
                              input string req);
    @(negedge clk);
    reg_addr = off;
    #1 check(reg_rdata === exp, req, reg_rdata, exp);
  endtask

  // Combinational check, then registered check one clock later
  task automatic look(input logic [31:0] a, input bit exp_hit,
                      input logic [4:0] exp_idx, input string req);
    @(negedge clk);
    lk_addr = a; lk_valid = 1'b1;
    #1;
    check(lk_hit === exp_hit, {req, " hit"}, {31'd0, lk_hit}, {31'd0, exp_hit});
    check(lk_idx === exp_idx, {req, " idx"}, {27'd0, lk_idx}, {27'd0, exp_idx});
    @(posedge clk);
    #1;
    check(q_valid === 1'b1 && q_hit === exp_hit && q_idx === exp_idx,
          "R9 registered result", {26'd0, q_valid, q_hit, q_idx},
          {26'd0, 1'b1, exp_hit, exp_idx});
    lk_valid = 1'b0;
  endtask

  task automatic t_reset();
    reg_read_chk(12'h060, 32'h0, "R1 reset readback");
    check(q_valid === 1'b0, "R1 q_valid after reset", {31'd0, q_valid}, 32'd0);
    look(32'hF000_0000, 1'b0, 5'd0, "R1 no hit after reset");
  endtask

  task automatic t_write_read();
    reg_write(12'h060, 32'hA5A5_0F3C);
    reg_read_chk(12'h060, 32'hA5A5_0F3C, "R2 readback");
  endtask

  task automatic t_stray_offset();
    reg_write(12'h060, 32'h0000_0004);
    reg_write(12'h064, 32'hFFFF_FFFF);
    reg_read_chk(12'h060, 32'h0000_0004, "R3 stray write ignored");
    reg_read_chk(12'h064, 32'h0, "R3 other offset reads zero");
    look(32'hF080_0000, 1'b0, 5'd0, "R3 slice1 not enabled");
  endtask

  task automatic t_card_bit1();
    reg_write(12'h060, 32'h0000_0002);
    look(32'hF080_0000, 1'b1, 5'd1, "R5 slice1 start (R10 right after write)");
    look(32'hF0FF_FFFF, 1'b1, 5'd1, "R5 slice1 end");
    look(32'hF07F_FFFF, 1'b0, 5'd0, "R5 below slice1");
    look(32'hF100_0000, 1'b0, 5'd0, "R5 above slice1");
  endtask

  task automatic t_card_bit30();
    reg_write(12'h060, 32'h4000_0000);
    look(32'hFF00_0000, 1'b1, 5'd30, "R5 slice30 start");
    look(32'hFF7F_FFFF, 1'b1, 5'd30, "R5 slice30 end");
    look(32'hFF80_0000, 1'b0, 5'd0, "R5 slice31 not enabled");
  endtask

  task automatic t_region();
    reg_write(12'h060, 32'hFFFF_FFFF);
    look(32'hE080_0000, 1'b0, 5'd0, "R4 nibble E misses");
    look(32'h7000_0000, 1'b0, 5'd0, "R4 low address misses");
    look(32'hFFFF_FFFF, 1'b1, 5'd31, "R4 top slice hits");
    look(32'hF5A0_1234, 1'b1, 5'd11, "R4 mid slice index");
  endtask

  task automatic t_zero();
    reg_write(12'h060, 32'h0);
    look(32'hF000_0000, 1'b0, 5'd0, "R6 zero enables slice0");
    look(32'hFF80_0000, 1'b0, 5'd0, "R6 zero enables slice31");
  endtask

  task automatic t_contiguous();
    reg_write(12'h060, 32'h0000_0070);
    look(32'hF27F_FFFF, 1'b1, 5'd4, "R8 end of slice4");
    look(32'hF280_0000, 1'b1, 5'd5, "R8 start of slice5");
    look(32'hF37F_FFFF, 1'b1, 5'd6, "R8 end of slice6");
    look(32'hF380_0000, 1'b0, 5'd0, "R8 past range (R7 idx zero)");
    look(32'hF1FF_FFFF, 1'b0, 5'd0, "R8 before range");
  endtask

  task automatic t_valid_low();
    @(negedge clk);
    lk_valid = 1'b0; lk_addr = 32'hF200_0000;
    @(posedge clk);
    #1 check(q_valid === 1'b0 && q_hit === 1'b0, "R9 idle stage",
             {30'd0, q_valid, q_hit}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_write_read();
    t_stray_offset();
    t_card_bit1();
    t_card_bit30();
    t_region();
    t_zero();
    t_contiguous();
    t_valid_low();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 32'd0, 32'd1);
      finish_run();
    end
  end
endmodule